// File: doc/BRIEF.md
# Word-Boundary Embedding Serializer

This block turns 22-bit parallel words into a single serial data line with a forwarded bit clock. A word is taken in on the rising edge of an asynchronous strobe and then sent as a 26-slot frame. The first 22 slots carry the data, least significant bit first. Two slots of zero follow. The frame closes with two boundary slots. During the boundary slots the forwarded clock does not go low, while the data line toggles twice. A receiver can therefore find each word end from the line pair alone, without a sync header or a separate frame signal.

The block runs from a system clock at twice the bit rate. A bit slot is two system cycles long: the forwarded clock is low in the first half and high in the second, and it is produced by a register. Frames follow each other on a fixed grid of 52 cycles whether or not there is data. A grid frame with no word to send is an idle frame: all its data slots are zero and its clock pattern is regular. A strobe that lands while a frame is being sent fills a one-word holding register, and that word goes out in the next frame. The strobe rate must not exceed one word per frame period.

Top module: `boundary_serializer`

## Requirements
- R1: While reset is applied, `sck_o` is 1 and `sd_o` is 0. After reset is released, the first 0 on `sck_o` marks half 0 of slot 0 of the first frame.
- R2: A frame is 26 slots of 2 system cycles each, and the frames follow each other with no gap. In each slot `sck_o` is 0 for the first cycle and 1 for the second, except in the boundary slots of a data frame (R6).
- R3: In a data frame, slot i (i = 0..21) carries bit i of the captured word.
- R4: Slots 22 and 23 of a data frame are 0.
- R5: Slot 24 of a data frame carries the inverse of slot 23, and slot 25 carries the same value as slot 23. Since slot 23 is always 0, the boundary sends 1 and then 0.
- R6: In a data frame, `sck_o` stays 1 through both halves of slots 24 and 25. With the high half of slot 23, this gives a high run of exactly 5 cycles. No run of 1 on `sck_o` lasts longer than 5 cycles.
- R7: `sd_o` changes only at the start of a slot. It never changes in the cycle where `sck_o` rises, and it holds the same value for both halves of a slot.
- R8: A rising edge on `strobe_i` captures `data_i` once it has been synchronized, at most 3 cycles after the edge. Each captured word is sent exactly once, in capture order, and its frame ends within 120 cycles of the strobe edge.
- R9: A grid frame with no word waiting is idle: `sd_o` is 0 in all 26 slots and the clock pattern is regular (R2).
- R10: A strobe held high for many frame periods sends its word only once. Only the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| strobe_i | input | 1 | Asynchronous word strobe; its rising edge captures `data_i` |
| data_i | input | DATA_W | Parallel word, held stable for at least 4 cycles after the strobe edge |
| sck_o | output | 1 | Forwarded bit clock, with the word boundary embedded |
| sd_o | output | 1 | Serial data, least significant bit first |

## Verification
The assertions check the line-level rules on every cycle: the forwarded clock's low phase lasts exactly one cycle, no high run exceeds five cycles, data never changes on a rising clock, the slot counter stays in range, and the holding register sets and clears as strobe edges and frame ends call for. Only the bench scenarios can show the rest. Those are the bit order and content of each frame, the exact boundary pattern, the zero content of idle frames, and whether every strobed word comes out once, in order, within its latency bound. Long strobe pulses, word-per-frame-rate bursts and extreme data patterns are among them.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // number of boundary slots appended after the padded word
  localparam int BND_W = 2;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } half_e;
endpackage

// File: rtl/bsr_strobe_capture.sv
module bsr_strobe_capture #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              frame_end_i,
  output logic              load_vld_o,
  output logic [DATA_W-1:0] load_word_o
);
  logic [2:0]        sync_q, sync_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hvld_q, hvld_d;
  logic              edge_w;

  assign edge_w = sync_q[1] & ~sync_q[2];

  always_comb begin
    sync_d = {sync_q[1:0], strobe_i};
    hold_d = hold_q;
    hvld_d = hvld_q;
    if (edge_w) begin
      hold_d = data_i;
      hvld_d = 1'b1;
    end else if (frame_end_i) begin
      hvld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hold_q <= '0;
      hvld_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      if (edge_w) hold_q <= hold_d;
      hvld_q <= hvld_d;
    end
  end

  assign load_vld_o  = hvld_q;
  assign load_word_o = hold_q;

  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> load_vld_o);
  // R8
  hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !edge_w) |=> !load_vld_o);
endmodule

// File: rtl/bsr_slot_timer.sv
module bsr_slot_timer #(
  parameter int FRAME_W = 26,
  parameter int SLOT_W  = $clog2(FRAME_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [SLOT_W-1:0]   slot_o,
  output bsr_pkg::half_e      half_o,
  output logic                frame_end_o
);
  import bsr_pkg::*;

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  half_e             ph_q, ph_d;

  always_comb begin
    ph_d   = (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    slot_d = slot_q;
    if (ph_q == PH_HIGH) begin
      slot_d = (slot_q == LAST) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ph_q   <= PH_LOW;
    end else begin
      slot_q <= slot_d;
      ph_q   <= ph_d;
    end
  end

  assign slot_o      = slot_q;
  assign half_o      = ph_q;
  assign frame_end_o = (ph_q == PH_HIGH) && (slot_q == LAST);

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST);
endmodule

// File: rtl/bsr_frame_shifter.sv
module bsr_frame_shifter #(
  parameter int DATA_W  = 22,
  parameter int WORD_W  = 24,
  parameter int FRAME_W = 26,
  parameter int SLOT_W  = $clog2(FRAME_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_W-1:0]   slot_i,
  input  bsr_pkg::half_e      half_i,
  input  logic                frame_end_i,
  input  logic                load_vld_i,
  input  logic [DATA_W-1:0]   load_word_i,
  output logic                sck_o,
  output logic                sd_o
);
  import bsr_pkg::*;

  logic [FRAME_W-1:0] built_w;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               fvld_q, fvld_d;
  logic               sck_q, sck_d, sd_q, sd_d;
  logic               boundary_w;

  // word, zero padding, then the two boundary slots derived from the last word slot
  always_comb begin
    built_w                = '0;
    built_w[DATA_W-1:0]    = load_word_i;
    built_w[WORD_W]        = ~built_w[WORD_W-1];
    built_w[WORD_W+1]      =  built_w[WORD_W-1];
  end

  always_comb begin
    frame_d = frame_q;
    fvld_d  = fvld_q;
    if (frame_end_i) begin
      frame_d = load_vld_i ? built_w : '0;
      fvld_d  = load_vld_i;
    end
  end

  assign boundary_w = fvld_q && (slot_i >= SLOT_W'(WORD_W));

  always_comb begin
    sck_d = (half_i == PH_HIGH) || boundary_w;
    sd_d  = frame_q[slot_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      fvld_q  <= 1'b0;
      sck_q   <= 1'b1;
      sd_q    <= 1'b0;
    end else begin
      if (frame_end_i) begin
        frame_q <= frame_d;
        fvld_q  <= fvld_d;
      end
      sck_q <= sck_d;
      sd_q  <= sd_d;
    end
  end

  assign sck_o = sck_q;
  assign sd_o  = sd_q;

  // checker state: length of the current high run on the forwarded clock
  logic [2:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run_q <= '0;
    else if (!sck_q) hi_run_q <= '0;
    else if (hi_run_q != 3'd7) hi_run_q <= hi_run_q + 3'd1;
  end

  // R6
  hi_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= 3'd5);
  // R2
  low_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |=> $rose(sck_o));
  // R7
  data_off_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> !$rose(sck_o));
endmodule

// File: rtl/boundary_serializer.sv
module boundary_serializer #(
  parameter int DATA_W = 22,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sck_o,
  output logic              sd_o
);
  import bsr_pkg::*;

  localparam int WORD_W  = DATA_W + PAD_W;
  localparam int FRAME_W = WORD_W + BND_W;
  localparam int SLOT_W  = $clog2(FRAME_W);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [SLOT_W-1:0] slot_w;
  half_e             half_w;
  logic              frame_end_w;
  logic              load_vld_w;
  logic [DATA_W-1:0] load_word_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  bsr_slot_timer #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .slot_o      (slot_w),
    .half_o      (half_w),
    .frame_end_o (frame_end_w)
  );

  bsr_strobe_capture #(.DATA_W(DATA_W)) u_capture (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .strobe_i    (strobe_i),
    .data_i      (data_i),
    .frame_end_i (frame_end_w),
    .load_vld_o  (load_vld_w),
    .load_word_o (load_word_w)
  );

  bsr_frame_shifter #(.DATA_W(DATA_W), .WORD_W(WORD_W), .FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_shifter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .slot_i      (slot_w),
    .half_i      (half_w),
    .frame_end_i (frame_end_w),
    .load_vld_i  (load_vld_w),
    .load_word_i (load_word_w),
    .sck_o       (sck_o),
    .sd_o        (sd_o)
  );
endmodule

// File: tb/boundary_serializer_test.sv
module boundary_serializer_test;
  localparam int DW = 22;
  localparam logic [51:0] CK_IDLE  = 52'hAAAAAAAAAAAAA;
  localparam logic [51:0] CK_VALID = 52'hFAAAAAAAAAAAA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe;
  logic [DW-1:0] data;
  logic          sck_o, sd_o;

  boundary_serializer uut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .data_i(data),
    .sck_o(sck_o), .sd_o(sd_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] exp_word [0:255];
  longint        exp_time [0:255];
  int wr_i = 0;
  int rd_i = 0;
  bit done = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: frame decoder aligned on the first low of the forwarded clock
  bit rst_seen = 1'b0;
  bit aligned = 1'b0;
  int k = 0;
  logic [51:0] ck_v;
  logic [25:0] sd_lo, sd_hi;

  task automatic eval_frame();
    if (ck_v[48]) begin
      logic [DW-1:0] w;
      longint t;
      if (rd_i < wr_i) begin
        w = exp_word[rd_i]; t = exp_time[rd_i]; rd_i++;
      end else begin
        w = '0; t = cyc;
        chk(1'b0, "R8 unexpected data frame", 64'(sd_lo), 64'h0);
      end
      chk(ck_v == CK_VALID, "R6 boundary clock", 64'(ck_v), 64'(CK_VALID));
      chk(sd_lo[21:0] == w, "R3 data slots", 64'(sd_lo[21:0]), 64'(w));
      chk(sd_lo[23:22] == 2'b00, "R4 pad slots", 64'(sd_lo[23:22]), 64'h0);
      chk({sd_lo[25], sd_lo[24]} == 2'b01, "R5 boundary data", 64'({sd_lo[25], sd_lo[24]}), 64'h1);
      chk(sd_hi == sd_lo, "R7 data stable in slot", 64'(sd_hi), 64'(sd_lo));
      chk(cyc - t <= 120, "R8 latency", 64'(cyc - t), 64'd120);
    end else begin
      chk(ck_v == CK_IDLE, "R2 regular clock", 64'(ck_v), 64'(CK_IDLE));
      chk(sd_lo == '0 && sd_hi == '0, "R9 idle data", 64'({sd_hi, sd_lo}), 64'h0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      if (!rst_seen) begin
        chk(sck_o === 1'b1 && sd_o === 1'b0, "R1 reset outputs", 64'({sck_o, sd_o}), 64'h2);
        rst_seen = 1'b1;
      end
      aligned = 1'b0;
    end else if (!done) begin
      if (!aligned && sck_o === 1'b0) begin
        aligned = 1'b1;
        k = 0;
      end
      if (aligned) begin
        int j;
        j = k % 52;
        ck_v[j] = sck_o;
        if (j % 2 == 0) sd_lo[j/2] = sd_o;
        else            sd_hi[j/2] = sd_o;
        if (j == 51) eval_frame();
        k++;
      end
    end
  end

  task automatic send(input logic [DW-1:0] w, input int hi_len, input int gap);
    @(posedge clk);
    #1;
    data   = w;
    strobe = 1'b1;
    exp_word[wr_i] = w;
    exp_time[wr_i] = cyc;
    wr_i++;
    repeat (hi_len) @(posedge clk);
    #1 strobe = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; strobe = 1'b0; data = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (120) @(posedge clk);   // two idle frames (R9)
    // directed patterns (R3, R5)
    send(22'h3FFFFF, 4, 60);
    send(22'h155555, 4, 60);
    send(22'h000000, 4, 60);
    send(22'h2AAAAA, 4, 60);
    // one long strobe, single word only (R10)
    send(22'h1C0FF3, 200, 60);
    // words at the full frame rate (R8)
    for (int i = 0; i < 12; i++) send(22'($urandom), 2, 54);
    // random spacing and pulse widths
    for (int i = 0; i < 40; i++) begin
      int hl;
      hl = 2 + int'($urandom % 20);
      send(22'($urandom), hl, 56 - hl + int'($urandom % 80));
    end
    repeat (300) @(posedge clk);
    done = 1'b1;
    chk(rd_i == wr_i, "R8 all words sent once", 64'(rd_i), 64'(wr_i));
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    finish_run();
  end
endmodule